// File: doc/BRIEF.md
# Card Clock Gate and Divider

This block derives the clock for a memory-card bus from the faster module clock. The division is a power of two set by a 3-bit exponent. Software turns the output on and off with write-one command bits. Clocks stop only after a whole card-clock period, so the card never sees a shortened pulse. The block also provides a strobe that marks card-clock activity for the data and command logic that runs in the module-clock domain.

A host writes command bits through a simplified register strobe. It stops the clock, programs the exponent, then restarts the clock. A command-launch bit placed in the same restart write produces a one-cycle launch pulse for the command engine. A soft-reset command stops the clock at once and holds a resetting flag for a fixed number of cycles, which software polls. Two flags report progress: one shows whether the clock is running, the other whether a soft reset is in progress.

Top module: `card_clk_gen`

## Requirements
- R1: With exponent d taken from the divide register (div_wdata_i, values 0 to 7, cleared to 0 by hard reset), the card clock period is 2^d module cycles. For d of 1 or more, each period begins low for 2^(d-1) cycles and then stays high for 2^(d-1) cycles. The first period begins in the cycle after the start write. For d = 0 the card clock follows the module clock, and its first high pulse falls in the second cycle after the start write.
- R2: Control bit 1 (start) is written while the clock is stopped, with bit 0 clear and no soft reset in progress. clk_running_o is then high in the cycle after the capturing edge.
- R3: Control bit 0 (stop) is written while the clock is running. The clock stops at the first edge that ends a complete card period: at once for d = 0, otherwise at the next period boundary. clk_running_o and the card clock are then low. A start write that arrives while a stop is waiting cancels that stop.
- R4: A write that sets bits 0 and 1 together acts as a stop. From the stopped state it leaves the clock stopped.
- R5: A divide write while the clock runs does not change the running period. The new value applies at the next start.
- R6: clk_en_o is high for one cycle in the cycle in which the card clock rises when d is 1 or more. When d = 0 it is high in every cycle that carries a card pulse. It is low while the clock is stopped.
- R7: op_launch_o pulses for one cycle, in the cycle after a write with bits 1 and 2 set, bit 0 clear and no soft reset in progress. Bit 2 alone gives no pulse. Bit 1 alone gives no pulse.
- R8: Control bit 3 (soft reset) takes priority over the other bits of the same write. It stops the clock in the next cycle and holds resetting_o high for exactly RST_CYCLES cycles (default 16). The divide register keeps its value.
- R9: While resetting_o is high, all control writes, including another soft reset, are ignored.
- R10: After hard reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 4 | Control bits: 0 stop, 1 start, 2 launch, 3 soft reset |
| div_we_i | input | 1 | Divide register write strobe |
| div_wdata_i | input | EXP_W | Power-of-two divide exponent |
| card_clk_o | output | 1 | Gated, divided card clock |
| clk_en_o | output | 1 | Card clock activity strobe in the module-clock domain |
| clk_running_o | output | 1 | Card clock is running |
| resetting_o | output | 1 | Soft reset in progress |
| op_launch_o | output | 1 | One-cycle command launch pulse |

## Verification
Running status, launch pulse and resetting flag each change in the cycle after the edge that captures the write. The bench therefore numbers cycles from that capture edge and samples one nanosecond after each rising edge. At that point the clock is high, so a d = 0 card pulse is visible. Card-clock and strobe values are predicted from the cycle index modulo 2^d. The stop edge is computed as the first multiple of the period at or after the edge that captures the stop. The soft-reset window is counted cycle by cycle against RST_CYCLES.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  // Control write fields; bit 0 is the least significant member.
  typedef struct packed {
    logic srst;   // bit 3
    logic op;     // bit 2
    logic start;  // bit 1
    logic stop;   // bit 0
  } ctl_cmd_t;

  localparam int unsigned CTL_W = $bits(ctl_cmd_t);

endpackage

// File: rtl/card_clk_rst_seq.sv
module card_clk_rst_seq #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic fire_o
);

  localparam int unsigned RW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [RW-1:0] LAST = RW'(RST_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  assign fire_o = trig_i & ~busy_q;
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    rcnt_d = rcnt_q;
    if (fire_o) begin
      busy_d = 1'b1;
      rcnt_d = LAST;
    end else if (busy_q) begin
      if (rcnt_q == '0) busy_d = 1'b0;
      else              rcnt_d = rcnt_q - RW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      rcnt_q <= rcnt_d;
    end
  end

  // R8: the resetting flag only rises on a soft-reset request
  p_busy_from_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(trig_i));

endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  ctl_cmd_t         cmd_i,
  input  logic             div_we_i,
  input  logic [EXP_W-1:0] div_wdata_i,
  input  logic             busy_i,
  input  logic             fire_i,
  input  logic             period_end_i,
  output logic             run_q_o,
  output logic             run_d_o,
  output logic [EXP_W-1:0] exp_q_o,
  output logic [EXP_W-1:0] exp_d_o,
  output logic             launch_o
);

  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             launch_q, launch_d;
  logic [EXP_W-1:0] div_q;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             exp_en;
  logic             accept, stop_cmd, start_cmd, stop_req;

  always_comb begin
    accept    = ctl_we_i & ~busy_i & ~cmd_i.srst;
    stop_cmd  = accept & cmd_i.stop;
    start_cmd = accept & cmd_i.start & ~cmd_i.stop;
    launch_d  = start_cmd & cmd_i.op;
    stop_req  = 1'b0;
    run_d     = run_q;
    pend_d    = pend_q;
    exp_d     = exp_q;
    exp_en    = 1'b0;
    if (fire_i) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
    end else if (run_q) begin
      stop_req = stop_cmd | (pend_q & ~start_cmd);
      if (stop_req && period_end_i) begin
        run_d  = 1'b0;
        pend_d = 1'b0;
      end else begin
        pend_d = stop_req;
      end
    end else if (start_cmd) begin
      run_d  = 1'b1;
      exp_d  = div_q;
      exp_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      pend_q   <= pend_d;
      launch_q <= launch_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (div_we_i) div_q <= div_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     exp_q <= '0;
    else if (exp_en) exp_q <= exp_d;
  end

  assign run_q_o  = run_q;
  assign run_d_o  = run_d;
  assign exp_q_o  = exp_q;
  assign exp_d_o  = exp_d;
  assign launch_o = launch_q;

  // R3: the clock only stops at a period boundary or under soft reset
  p_stop_on_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> ($past(period_end_i) || $past(fire_i)));

  // R5: the exponent in use is frozen while the clock runs
  p_exp_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(exp_q));

  // R7: a launch pulse always comes with a running clock
  p_launch_running_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_q |-> run_q);

  // R9: no clock activity while the soft reset is in progress
  p_reset_blocks_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !run_q);

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int unsigned EXP_W = 3,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_q_i,
  input  logic             run_d_i,
  input  logic [EXP_W-1:0] exp_q_i,
  input  logic [EXP_W-1:0] exp_d_i,
  output logic             card_o,
  output logic             en_o,
  output logic             period_end_o
);

  logic [CNT_W-1:0] mask_q, mask_d, half_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             card_q, card_d;
  logic             en_q, en_d;

  // Thermometer masks: bit b is set when the exponent exceeds b.
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask_q[b] = (32'(exp_q_i) > b);
    assign mask_d[b] = (32'(exp_d_i) > b);
  end

  assign half_d       = mask_d ^ (mask_d >> 1);
  assign period_end_o = (cnt_q == mask_q);

  always_comb begin
    if (run_d_i && run_q_i) cnt_d = (cnt_q + CNT_W'(1)) & mask_d;
    else                    cnt_d = '0;
    card_d = run_d_i & (|(cnt_d & half_d));
    if (exp_d_i == '0) en_d = run_q_i;
    else               en_d = run_d_i & (cnt_d == half_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      card_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      card_q <= card_d;
      en_q   <= en_d;
    end
  end

  assign card_o = card_q;
  assign en_o   = en_q;

  // R3: the divided clock is low whenever the clock is stopped
  p_card_low_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q_i |-> !card_q);

  // R6: for divided rates the strobe marks the rising cycle
  p_strobe_at_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && exp_q_i != '0) |-> (card_q && !$past(card_q)));

endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic exp_zero_i,
  input  logic card_div_i,
  output logic card_clk_o
);

  logic gate_q;

  // Updated while the module clock is low, so the AND never clips a pulse.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_i & exp_zero_i;
  end

  assign card_clk_o = exp_zero_i ? (clk_i & gate_q) : card_div_i;

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int unsigned EXP_W      = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [3:0]       ctl_wdata_i,
  input  logic             div_we_i,
  input  logic [EXP_W-1:0] div_wdata_i,
  output logic             card_clk_o,
  output logic             clk_en_o,
  output logic             clk_running_o,
  output logic             resetting_o,
  output logic             op_launch_o
);

  localparam int unsigned MAX_EXP = (1 << EXP_W) - 1;
  localparam int unsigned CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  ctl_cmd_t         cmd;
  logic             busy, fire, period_end;
  logic             run_q, run_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             card_div, en, launch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cmd = ctl_cmd_t'(ctl_wdata_i[CTL_W-1:0]);

  card_clk_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .trig_i (ctl_we_i & cmd.srst),
    .busy_o (busy),
    .fire_o (fire)
  );

  card_clk_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .ctl_we_i     (ctl_we_i),
    .cmd_i        (cmd),
    .div_we_i     (div_we_i),
    .div_wdata_i  (div_wdata_i),
    .busy_i       (busy),
    .fire_i       (fire),
    .period_end_i (period_end),
    .run_q_o      (run_q),
    .run_d_o      (run_d),
    .exp_q_o      (exp_q),
    .exp_d_o      (exp_d),
    .launch_o     (launch)
  );

  card_clk_div #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .run_q_i      (run_q),
    .run_d_i      (run_d),
    .exp_q_i      (exp_q),
    .exp_d_i      (exp_d),
    .card_o       (card_div),
    .en_o         (en),
    .period_end_o (period_end)
  );

  card_clk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run_q),
    .exp_zero_i (exp_q == '0),
    .card_div_i (card_div),
    .card_clk_o (card_clk_o)
  );

  assign clk_en_o      = en;
  assign clk_running_o = run_q;
  assign resetting_o   = busy;
  assign op_launch_o   = launch;

endmodule

// File: tb/card_clk_gen_bench.sv
`timescale 1ns/1ps
module card_clk_gen_bench;

  logic       clk;
  logic       rst_n;
  logic       ctl_we;
  logic [3:0] ctl_wdata;
  logic       div_we;
  logic [2:0] div_wdata;
  logic       card, en, run, resetting, launch;
  int         n_chk;
  int         n_fail;

  card_clk_gen u_card_clk_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ctl_we_i      (ctl_we),
    .ctl_wdata_i   (ctl_wdata),
    .div_we_i      (div_we),
    .div_wdata_i   (div_wdata),
    .card_clk_o    (card),
    .clk_en_o      (en),
    .clk_running_o (run),
    .resetting_o   (resetting),
    .op_launch_o   (launch)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp_v, $time);
    end
  endtask

  // Advance to 1 ns after the next rising edge (clock high).
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl(input logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0; ctl_wdata = 4'b0;
  endtask

  task automatic setdiv(input int e);
    div_we = 1'b1; div_wdata = 3'(e);
    step();
    div_we = 1'b0;
  endtask

  function automatic logic exp_card(input int e, input int j);
    int p = 1 << e;
    if (e == 0) return j >= 1;
    return (j % p) >= (p / 2);
  endfunction

  function automatic logic exp_en(input int e, input int j);
    int p = 1 << e;
    if (e == 0) return j >= 1;
    return (j % p) == (p / 2);
  endfunction

  task automatic stop_and_wait();
    ctl(4'b0001);
    for (int i = 0; i < 300 && run; i++) step();
    chk("R3 clock stopped", run, 1'b0);
    chk("R3 card low after stop", card, 1'b0);
  endtask

  // Start with exponent e, stop at cycle j0 = 2P+o, check every cycle.
  task automatic sweep_case(input int e, input int o);
    int  p  = 1 << e;
    int  j0 = 2 * p + o;
    int  sk = -1;
    logic xr, xc, xe;
    setdiv(e);
    ctl(4'b0110);
    for (int j = 0; j < 5000; j++) begin
      xr = (sk < 0) || (j < sk);
      if (e == 0) begin
        xc = (j >= 1) && ((sk < 0) || (j <= sk));
        xe = xc;
      end else begin
        xc = xr && exp_card(e, j);
        xe = xr && exp_en(e, j);
      end
      chk("R2/R3 running flag", run, xr);
      chk("R1/R5 card clock", card, xc);
      chk("R6 strobe", en, xe);
      chk("R7 launch pulse", launch, j == 0);
      if (sk >= 0 && j >= sk + 1) break;
      if (j == 1) begin div_we = 1'b1; div_wdata = 3'(7 - e); end
      if (j == j0) begin
        ctl_we = 1'b1; ctl_wdata = 4'b0001;
        sk = ((j0 + p) / p) * p;
      end
      step();
      div_we = 1'b0; ctl_we = 1'b0; ctl_wdata = 4'b0;
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = 4'b0; div_we = 1'b0; div_wdata = 3'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R10: outputs after hard reset
    chk("R10 running", run, 1'b0);
    chk("R10 resetting", resetting, 1'b0);
    chk("R10 card", card, 1'b0);
    chk("R10 strobe", en, 1'b0);
    chk("R10 launch", launch, 1'b0);

    // R1: divide register resets to 0, so the clock follows the module clock
    ctl(4'b0010);
    chk("R2 running after start", run, 1'b1);
    chk("R1 first cycle low", card, 1'b0);
    step();
    chk("R1 d=0 pulse", card, 1'b1);
    chk("R6 d=0 strobe", en, 1'b1);
    ctl(4'b0001);
    chk("R3 d=0 immediate stop", run, 1'b0);
    chk("R3 last full pulse", card, 1'b1);
    step();
    chk("R3 card low", card, 1'b0);
    chk("R6 strobe low stopped", en, 1'b0);

    // R1, R3, R5, R6, R7: sweep all exponents with varied stop points
    for (int e = 0; e < 8; e++) sweep_case(e, (3 * e + 1) % (1 << e));
    sweep_case(2, 3);
    sweep_case(3, 0);

    // R5: the value written while running (4) applies at the next start
    ctl(4'b0010);
    chk("R7 no launch without op", launch, 1'b0);
    for (int j = 0; j < 20; j++) begin
      chk("R5 new divide at restart", card, exp_card(4, j));
      step();
    end
    stop_and_wait();

    // R4: start and stop together act as stop
    ctl(4'b0011);
    chk("R4 stays stopped", run, 1'b0);
    chk("R4 no launch", launch, 1'b0);
    step();
    chk("R4 card low", card, 1'b0);

    // R7: launch bit alone does nothing
    ctl(4'b0100);
    chk("R7 op alone no launch", launch, 1'b0);
    chk("R7 op alone no start", run, 1'b0);

    // R3: a start during a pending stop cancels it
    setdiv(2);
    ctl(4'b0010);
    step();
    ctl(4'b0001);
    ctl(4'b0010);
    chk("R7 running start without op", launch, 1'b0);
    repeat (3) step();
    chk("R3 pending stop cancelled", run, 1'b1);
    chk("R3 waveform continues", card, exp_card(2, 6));

    // R8, R9: soft reset with start in the same write, then ignored writes
    ctl(4'b1010);
    for (int i = 0; i < 18; i++) begin
      chk("R8 resetting window", resetting, i < 16);
      chk("R8 stopped by reset", run, 1'b0);
      chk("R8 card low in reset", card, 1'b0);
      chk("R9 no launch in reset", launch, 1'b0);
      if (i == 3) begin ctl_we = 1'b1; ctl_wdata = 4'b0110; end
      if (i == 5) begin ctl_we = 1'b1; ctl_wdata = 4'b1000; end
      step();
      ctl_we = 1'b0; ctl_wdata = 4'b0;
    end

    // R8: divide setting survives the soft reset
    ctl(4'b0010);
    for (int j = 0; j < 10; j++) begin
      chk("R8 divide kept", card, exp_card(2, j));
      step();
    end
    stop_and_wait();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule